// File: doc/BRIEF.md
# Hitless Reference Switchover Controller

This block sits between two digitized phase detectors, one per redundant reference clock (A and B), and the digital loop filter of a clock-cleaning PLL. One reference is active at a time. The loop sees the active reference's phase error minus a stored offset for that reference. The offset of the standby reference keeps following its own raw error, so that its corrected error always equals the loop's current error. When the selection moves, the standby offset is simply kept and used, and the phase handed to the loop does not jump.

All phase quantities are unsigned codes taken modulo 2^(STEP_W+WRAP_W). One code is one offset-DAC step. A half phase-detector full scale is 2^STEP_W codes, so the default of 32 gives 64 codes per full scale. An active offset is split into two fields. The low STEP_W bits drive the offset DAC. The upper WRAP_W bits count whole half-scale steps, from 0 to 7 by default. These steps are removed one at a time by asking the VCO divider to swallow pulses. Arithmetic modulo eight half-scale steps makes any offset, positive or negative, reachable with at most seven swallows.

The selection follows a manual select input, or, in automatic mode, moves away from a reference that reports loss of signal. When both references report loss of signal, the selection is frozen and a holdover flag is raised.

Top module: `hitless_refsw`

## Requirements
- R1: After synchronous reset, reference A is active (`active_sel`=0), both offsets are zero, and `phase_out`, `dac_code`, `swallow_req` and `holdover` are all 0.
- R2: `phase_out` is registered. One cycle after an edge it equals (active error − active offset) mod 2^8, using the selection and offset held before that edge.
- R3: Each cycle the standby reference's offset is loaded with (standby error − current loop error) mod 2^8. With steady inputs, `phase_out` in the cycle after a switchover has taken effect equals its value before the switchover.
- R4: With `auto_en`=0, no swallow outstanding and no double loss of signal, the selection moves to `man_sel` (0=A, 1=B) on the next edge.
- R5: With `auto_en`=1, `man_sel` is ignored. The selection moves away from the active reference on the next edge when that reference reports loss of signal and the other does not.
- R6: While `los_a` and `los_b` are both 1, the selection does not change, and `holdover` is 1 on the following cycle.
- R7: `dac_code` equals bits [4:0] of the active offset. Bits [7:5] of that offset are the number of half-scale steps still to be swallowed.
- R8: While that count is nonzero and no swallow is outstanding, a single-cycle `swallow_req` is issued. No further request is issued until `swallow_ack` is seen. Each acknowledge lowers the active offset by 32 codes. No request is issued in a cycle in which a switchover takes place.
- R9: A switchover demanded while a swallow is outstanding is deferred. This includes the acknowledge cycle. An acknowledge with no swallow outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_a | input | 8 | Digitized phase error of reference A |
| err_b | input | 8 | Digitized phase error of reference B |
| los_a | input | 1 | Loss of signal on reference A |
| los_b | input | 1 | Loss of signal on reference B |
| man_sel | input | 1 | Manual selection, 0=A, 1=B |
| auto_en | input | 1 | Automatic switchover on loss of signal |
| swallow_ack | input | 1 | Pulse-swallow completed |
| phase_out | output | 8 | Offset-corrected phase error to the loop filter |
| active_sel | output | 1 | Active reference, 0=A, 1=B |
| dac_code | output | 5 | Offset DAC code |
| swallow_req | output | 1 | Single-cycle pulse-swallow request |
| holdover | output | 1 | Both references lost |

## Verification
A switchover demand and a swallow acknowledge can arrive in the same cycle. The two compete for the active offset, since one latches a new active offset and the other decrements it. The bench provokes this by holding the acknowledge back after a large-offset switchover, then flipping `man_sel` while the request is outstanding and releasing the acknowledge later. The selection must stay put through the acknowledge cycle and move on the edge after it. A cycle model built from the requirements judges every output on every cycle, and a sweep over all 256 offset differences checks the swallow count and phase continuity of each switchover.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic {
        REF_A = 1'b0,
        REF_B = 1'b1
    } ref_e;

    typedef struct packed {
        logic sw;
        logic hold;
    } sel_ctl_t;

    function automatic logic switch_wanted(
        input ref_e cur,
        input logic auto_en,
        input logic man,
        input logic la,
        input logic lb
    );
        logic want;
        if (auto_en) begin
            want = (cur == REF_A) ? (la && !lb) : (lb && !la);
        end else begin
            want = (man != logic'(cur));
        end
        return want;
    endfunction

    function automatic ref_e other_ref(input ref_e cur);
        return (cur == REF_A) ? REF_B : REF_A;
    endfunction

endpackage

// File: rtl/ref_select.sv
module ref_select
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic los_a,
    input  logic los_b,
    input  logic auto_en,
    input  logic man_sel,
    input  logic busy,
    output ref_e sel,
    output logic sw_now,
    output logic holdover
);
    sel_ctl_t ctl;

    always_comb begin
        ctl.hold = los_a && los_b;
        ctl.sw   = switch_wanted(sel, auto_en, man_sel, los_a, los_b)
                   && !busy && !ctl.hold;
    end

    assign sw_now = ctl.sw;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel      <= REF_A;
            holdover <= 1'b0;
        end else begin
            holdover <= ctl.hold;
            if (ctl.sw) begin
                sel <= other_ref(sel);
            end
        end
    end
endmodule

// File: rtl/offset_bank.sv
module offset_bank
    import hs_pkg::*;
#(
    parameter int STEP_W = 5,
    parameter int WRAP_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [STEP_W+WRAP_W-1:0]  err_a,
    input  logic [STEP_W+WRAP_W-1:0]  err_b,
    input  ref_e                      sel,
    input  logic                      dec,
    output logic [STEP_W+WRAP_W-1:0]  off_act,
    output logic [STEP_W+WRAP_W-1:0]  phase_q
);
    localparam int PH_W = STEP_W + WRAP_W;
    localparam logic [PH_W-1:0] STEP = PH_W'(1 << STEP_W);

    logic [PH_W-1:0] err_v [2];
    logic [PH_W-1:0] off_q [2];
    logic [PH_W-1:0] loop_err;

    assign err_v[0] = err_a;
    assign err_v[1] = err_b;
    assign off_act  = off_q[sel];
    assign loop_err = err_v[sel] - off_q[sel];

    for (genvar g = 0; g < 2; g++) begin : g_ref
        always_ff @(posedge clk) begin
            if (rst) begin
                off_q[g] <= '0;
            end else if (logic'(sel) != g[0]) begin
                off_q[g] <= err_v[g] - loop_err;
            end else if (dec) begin
                off_q[g] <= off_q[g] - STEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= loop_err;
        end
    end
endmodule

// File: rtl/swallow_seq.sv
module swallow_seq (
    input  logic clk,
    input  logic rst,
    input  logic k_nz,
    input  logic block,
    input  logic ack,
    output logic req,
    output logic busy,
    output logic dec
);
    logic issue;

    assign issue = !busy && k_nz && !block;
    assign dec   = busy && ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            busy <= 1'b0;
        end else begin
            req <= issue;
            if (issue) begin
                busy <= 1'b1;
            end else if (dec) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hitless_refsw.sv
module hitless_refsw
    import hs_pkg::*;
#(
    parameter int STEP_W = 5,
    parameter int WRAP_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [STEP_W+WRAP_W-1:0] err_a,
    input  logic [STEP_W+WRAP_W-1:0] err_b,
    input  logic                     los_a,
    input  logic                     los_b,
    input  logic                     man_sel,
    input  logic                     auto_en,
    input  logic                     swallow_ack,
    output logic [STEP_W+WRAP_W-1:0] phase_out,
    output logic                     active_sel,
    output logic [STEP_W-1:0]        dac_code,
    output logic                     swallow_req,
    output logic                     holdover
);
    localparam int PH_W = STEP_W + WRAP_W;

    ref_e            sel;
    logic            sw_now;
    logic            swl_busy;
    logic            swl_dec;
    logic            k_nz;
    logic [PH_W-1:0] off_act;

    ref_select u_sel (
        .clk      (clk),
        .rst      (rst),
        .los_a    (los_a),
        .los_b    (los_b),
        .auto_en  (auto_en),
        .man_sel  (man_sel),
        .busy     (swl_busy),
        .sel      (sel),
        .sw_now   (sw_now),
        .holdover (holdover)
    );

    offset_bank #(.STEP_W(STEP_W), .WRAP_W(WRAP_W)) u_off (
        .clk     (clk),
        .rst     (rst),
        .err_a   (err_a),
        .err_b   (err_b),
        .sel     (sel),
        .dec     (swl_dec),
        .off_act (off_act),
        .phase_q (phase_out)
    );

    assign k_nz = |off_act[PH_W-1:STEP_W];

    swallow_seq u_swl (
        .clk   (clk),
        .rst   (rst),
        .k_nz  (k_nz),
        .block (sw_now),
        .ack   (swallow_ack),
        .req   (swallow_req),
        .busy  (swl_busy),
        .dec   (swl_dec)
    );

    assign active_sel = logic'(sel);
    assign dac_code   = off_act[STEP_W-1:0];
endmodule

// File: rtl/hs_checker.sv
module hs_checker (
    input logic clk,
    input logic rst,
    input logic los_a,
    input logic los_b,
    input logic man_sel,
    input logic auto_en,
    input logic busy,
    input logic active_sel,
    input logic swallow_req,
    input logic holdover
);
    // R8
    swallow_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        swallow_req |=> !swallow_req);

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (los_a && los_b) |=> (holdover && active_sel == $past(active_sel)));

    // R9
    defer_switch_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(active_sel));

    // R5
    auto_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !busy && (active_sel ? (los_b && !los_a) : (los_a && !los_b)))
        |=> active_sel != $past(active_sel));

    // R4
    manual_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && !busy && !(los_a && los_b) && man_sel != active_sel)
        |=> active_sel == $past(man_sel));
endmodule

bind hitless_refsw hs_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .los_a       (los_a),
    .los_b       (los_b),
    .man_sel     (man_sel),
    .auto_en     (auto_en),
    .busy        (swl_busy),
    .active_sel  (active_sel),
    .swallow_req (swallow_req),
    .holdover    (holdover)
);

// File: tb/tb_hitless_refsw.sv
module tb_hitless_refsw;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ea = '0, eb = '0;
    logic       la = 1'b0, lb = 1'b0, man = 1'b0, aut = 1'b0, ack = 1'b0;
    logic [7:0] phase_out;
    logic       active_sel, swallow_req, holdover;
    logic [4:0] dac_code;

    int n_chk = 0, n_fail = 0;
    bit auto_ack = 1'b1;
    int ack_cnt = 0;
    int req_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hitless_refsw dut (
        .clk(clk), .rst(rst), .err_a(ea), .err_b(eb), .los_a(la), .los_b(lb),
        .man_sel(man), .auto_en(aut), .swallow_ack(ack),
        .phase_out(phase_out), .active_sel(active_sel), .dac_code(dac_code),
        .swallow_req(swallow_req), .holdover(holdover)
    );

    // cycle model built from the requirements
    logic       m_sel, m_busy, m_req, m_hold;
    logic [7:0] m_off [2];
    logic [7:0] m_out;
    logic [7:0] t_y;
    logic       t_sw, t_want;

    always @(posedge clk) begin
        if (rst) begin
            m_sel <= 1'b0; m_busy <= 1'b0; m_req <= 1'b0; m_hold <= 1'b0;
            m_off[0] <= '0; m_off[1] <= '0; m_out <= '0;
        end else begin
            t_y    = (m_sel ? eb : ea) - m_off[m_sel];
            t_want = aut ? (m_sel ? (lb && !la) : (la && !lb)) : (man != m_sel);
            t_sw   = t_want && !m_busy && !(la && lb);
            m_req  <= !m_busy && (m_off[m_sel][7:5] != 3'd0) && !t_sw;
            if (!m_busy && (m_off[m_sel][7:5] != 3'd0) && !t_sw) m_busy <= 1'b1;
            else if (m_busy && ack) m_busy <= 1'b0;
            m_off[!m_sel] <= (m_sel ? ea : eb) - t_y;
            if (m_busy && ack) m_off[m_sel] <= m_off[m_sel] - 8'd32;
            if (t_sw) m_sel <= !m_sel;
            m_out  <= t_y;
            m_hold <= la && lb;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance one cycle: judge outputs at the falling edge, then answer swallows
    task automatic tick();
        @(negedge clk);
        if (!rst) begin
            chk(phase_out == m_out, "R2 phase_out", phase_out, m_out);
            chk(active_sel == m_sel, "R4/R5 active_sel", active_sel, m_sel);
            chk(dac_code == m_off[m_sel][4:0], "R7 dac_code", dac_code, m_off[m_sel][4:0]);
            chk(swallow_req == m_req, "R8 swallow_req", swallow_req, m_req);
            chk(holdover == m_hold, "R6 holdover", holdover, m_hold);
        end
        if (swallow_req) req_seen++;
        if (auto_ack && swallow_req) ack_cnt = 2;
        ack = auto_ack && (ack_cnt == 1);
        if (ack_cnt > 0) ack_cnt--;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] p0, inc, ein;
        logic       s0;
        ticks(3);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(active_sel == 1'b0, "R1 sel", active_sel, 0);
        chk(phase_out == 8'd0, "R1 phase_out", phase_out, 0);
        chk(dac_code == 5'd0 && !swallow_req && !holdover, "R1 flags", dac_code, 0);

        // R2/R3: standby error sweep while A stays active
        for (int v = 0; v < 256; v++) begin
            ea = 8'(v * 7 + 3); eb = 8'(v);
            tick();
        end

        // R3/R7/R8: a switchover for every offset difference
        for (int d = 0; d < 256; d++) begin
            ea = 8'(d * 37 + 11); eb = ea + 8'(d);
            ticks(2);
            p0 = phase_out;
            s0 = active_sel;
            ein = s0 ? ea : eb;
            inc = ein - p0;
            req_seen = 0;
            man = !s0;
            ticks(2);
            chk(active_sel == !s0, "R4 manual switch", active_sel, !s0);
            chk(phase_out == p0, "R3 continuity", phase_out, p0);
            ticks(48);
            chk(req_seen == int'(inc[7:5]), "R8 swallow count", req_seen, inc[7:5]);
            chk(dac_code == inc[4:0], "R7 residual", dac_code, inc[4:0]);
        end

        // R5: automatic mode, manual select ignored
        aut = 1'b1; man = !active_sel; s0 = active_sel;
        ticks(4);
        chk(active_sel == s0, "R5 man_sel ignored", active_sel, s0);
        if (s0) lb = 1'b1; else la = 1'b1;
        ticks(2);
        chk(active_sel == !s0, "R5 los switch", active_sel, !s0);
        ticks(40);

        // R6: double loss freezes the selection
        la = 1'b1; lb = 1'b1; s0 = active_sel;
        ticks(5);
        chk(holdover == 1'b1, "R6 holdover", holdover, 1);
        chk(active_sel == s0, "R6 held", active_sel, s0);
        la = 1'b0; lb = 1'b0;
        ticks(40);

        // R9: switchover demanded while a swallow is outstanding
        aut = 1'b0; man = active_sel; auto_ack = 1'b0;
        ea = 8'd10; eb = 8'd200;
        ticks(40);
        s0 = active_sel;
        man = !s0;
        ticks(2);
        chk(active_sel == !s0, "R4 switch before defer", active_sel, !s0);
        chk(swallow_req == 1'b1 || m_busy, "R8 request pending", swallow_req, 1);
        s0 = active_sel;
        man = !s0;
        ticks(6);
        chk(active_sel == s0, "R9 deferred", active_sel, s0);
        @(negedge clk); ack = 1'b1;
        tick();
        ack = 1'b0;
        chk(active_sel == s0, "R9 held in ack cycle", active_sel, s0);
        tick();
        chk(active_sel == !s0, "R9 switch after ack", active_sel, !s0);
        auto_ack = 1'b1;
        ticks(48);

        // R9: acknowledge with nothing outstanding is ignored
        p0 = {3'd0, dac_code};
        @(negedge clk); ack = 1'b1;
        tick();
        ack = 1'b0;
        ticks(2);
        chk(dac_code == p0[4:0], "R9 idle ack", dac_code, p0[4:0]);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule